// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

This block gathers 64 level-sensitive interrupt request lines and keeps a pending bit for each. A small register window, reached over a single-cycle synchronous read/write port with byte offsets in a 256-byte space, holds a 64-bit mask, a 64-bit software force vector and an 8-bit priority level for each source. A source takes part in arbitration only while its level is nonzero.

From the registered state the block picks the highest-level active source. It drives that source's level and vector number towards the CPU. Software can read the same vector through an acknowledge offset. A pair of command offsets sets or clears one mask bit, or the whole mask, with a single byte write.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_level_o` is 0 and `irq_vector_o` is 24. The mask reads as all ones. Pending, force and every level byte read as zero.
- R2: Pending bit n follows `irq_i[n]` one clock later. It reads at offset 0x00 (sources 63..32, bit 0 = source 32) and at offset 0x04 (sources 31..0, bit 0 = source 0).
- R3: Writes to offsets 0x00 and 0x04 leave the pending bits unchanged.
- R4: Level byte n sits at offset 0x40+n in bits [7:0]. Writing a nonzero value enables source n, and writing zero disables it.
- R5: Source n is active when (pending[n] OR force[n]) AND enabled[n] AND NOT mask[n].
- R6: The winner is the active source with the largest level. When levels are equal, the higher source index wins.
- R7: With a winner, `irq_level_o` is its level and `irq_vector_o` is its index plus 64. With no active source, the outputs are 0 and 24.
- R8: The mask's upper half (sources 63..32) is written and read at 0x08, and its lower half at 0x0C.
- R9: The force vector's upper half is written and read at 0x10, and its lower half at 0x14.
- R10: A write to 0x1C sets the mask bit selected by data bits [5:0]. When data bit 6 is 1, it sets all 64 mask bits instead.
- R11: A write to 0x1D clears the mask bit selected by data bits [5:0]. When data bit 6 is 1, it clears the whole mask instead.
- R12: A read at 0xE0 returns the current vector, zero-extended. A read at any unmapped offset returns zero.
- R13: The outputs reflect a change to a request line, mask, force or level register one clock edge after that change is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 64 | Level-sensitive request lines, one per source |
| bus_we_i | input | 1 | Register write strobe, one cycle per write |
| bus_addr_i | input | 8 | Byte offset in the register window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_level_o | output | 8 | Level of the winning source, 0 when idle |
| irq_vector_o | output | 8 | Vector of the winning source, 24 when idle |

## Verification
The assertions assume that `irq_i` is synchronous to `clk_i`. They also assume that every write is a single-cycle strobe whose address and data are stable across the sampling edge. Without that, the one-clock relations between a command write and the mask or enable state do not hold. The stimulus changes every input only on the falling edge and releases the write strobe after exactly one rising edge. Request lines are raised and dropped only on the falling edge, which keeps the pending bits and their checks free of races.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam logic [7:0] OFS_PEND_HI  = 8'h00;
  localparam logic [7:0] OFS_PEND_LO  = 8'h04;
  localparam logic [7:0] OFS_MASK_HI  = 8'h08;
  localparam logic [7:0] OFS_MASK_LO  = 8'h0C;
  localparam logic [7:0] OFS_FORCE_HI = 8'h10;
  localparam logic [7:0] OFS_FORCE_LO = 8'h14;
  localparam logic [7:0] OFS_MASK_SET = 8'h1C;
  localparam logic [7:0] OFS_MASK_CLR = 8'h1D;
  localparam logic [7:0] OFS_ACK      = 8'hE0;
  localparam int unsigned LVL_BASE    = 64;
  localparam int unsigned VEC_BASE    = 64;
  localparam int unsigned VEC_IDLE    = 24;
  localparam int unsigned ALL_BIT     = 6;
endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned LVL_W   = 8,
  parameter int unsigned DW      = 32,
  parameter int unsigned AW      = 8,
  localparam int unsigned SEL_W  = $clog2(NUM_SRC),
  localparam int unsigned HALF   = NUM_SRC / 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_SRC-1:0]             irq_i,
  input  logic                           we_i,
  input  logic [AW-1:0]                  addr_i,
  input  logic [DW-1:0]                  wdata_i,
  output logic [NUM_SRC-1:0]             pend_o,
  output logic [NUM_SRC-1:0]             mask_o,
  output logic [NUM_SRC-1:0]             force_o,
  output logic [NUM_SRC-1:0]             en_o,
  output logic [NUM_SRC-1:0][LVL_W-1:0]  lvl_o
);
  logic [NUM_SRC-1:0]            pend_q, mask_q, force_q, en_q;
  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q;
  logic [SEL_W-1:0]              sel;

  assign sel = wdata_i[SEL_W-1:0];

  // pending bits track the lines only; bus writes never reach them
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= irq_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
    end else if (we_i) begin
      case (addr_i)
        OFS_MASK_HI: mask_q[NUM_SRC-1:HALF] <= wdata_i[HALF-1:0];
        OFS_MASK_LO: mask_q[HALF-1:0]       <= wdata_i[HALF-1:0];
        OFS_MASK_SET: begin
          if (wdata_i[ALL_BIT]) mask_q <= '1;
          else                  mask_q[sel] <= 1'b1;
        end
        OFS_MASK_CLR: begin
          if (wdata_i[ALL_BIT]) mask_q <= '0;
          else                  mask_q[sel] <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      force_q <= '0;
    end else if (we_i) begin
      if (addr_i == OFS_FORCE_HI) force_q[NUM_SRC-1:HALF] <= wdata_i[HALF-1:0];
      if (addr_i == OFS_FORCE_LO) force_q[HALF-1:0]       <= wdata_i[HALF-1:0];
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl
    logic hit;
    assign hit = we_i && (addr_i == AW'(LVL_BASE + g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lvl_q[g] <= '0;
        en_q[g]  <= 1'b0;
      end else if (hit) begin
        lvl_q[g] <= wdata_i[LVL_W-1:0];
        en_q[g]  <= |wdata_i[LVL_W-1:0];
      end
    end
  end

  assign pend_o  = pend_q;
  assign mask_o  = mask_q;
  assign force_o = force_q;
  assign en_o    = en_q;
  assign lvl_o   = lvl_q;

  // R3
  pend_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && (addr_i == OFS_PEND_HI || addr_i == OFS_PEND_LO) |=> pend_q == $past(irq_i));
  // R4
  lvl_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i >= AW'(LVL_BASE) && addr_i < AW'(LVL_BASE + NUM_SRC)
    |=> en_q[$past(addr_i[SEL_W-1:0])] == $past(|wdata_i[LVL_W-1:0]));
  // R10
  mask_set_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == OFS_MASK_SET && wdata_i[ALL_BIT] |=> &mask_q);
  // R11
  mask_clr_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == OFS_MASK_CLR && wdata_i[ALL_BIT] |=> mask_q == '0);
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned LVL_W   = 8,
  localparam int unsigned SEL_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]            act_i,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_i,
  output logic                          hit_o,
  output logic [SEL_W-1:0]              idx_o,
  output logic [LVL_W-1:0]              lvl_o
);
  // ascending scan with >= so the later (higher) index takes ties
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    lvl_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (act_i[i] && lvl_i[i] >= lvl_o) begin
        hit_o = 1'b1;
        idx_o = SEL_W'(i);
        lvl_o = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned LVL_W   = 8,
  parameter int unsigned DW      = 32,
  parameter int unsigned AW      = 8,
  parameter int unsigned VEC_W   = 8,
  localparam int unsigned SEL_W  = $clog2(NUM_SRC),
  localparam int unsigned HALF   = NUM_SRC / 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               bus_we_i,
  input  logic [AW-1:0]      bus_addr_i,
  input  logic [DW-1:0]      bus_wdata_i,
  output logic [DW-1:0]      bus_rdata_o,
  output logic [LVL_W-1:0]   irq_level_o,
  output logic [VEC_W-1:0]   irq_vector_o
);
  logic [NUM_SRC-1:0]            pend, mask, frc, en, act;
  logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
  logic                          hit;
  logic [SEL_W-1:0]              win_idx;
  logic [LVL_W-1:0]              win_lvl;

  irq_regfile #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .DW(DW), .AW(AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .irq_i   (irq_i),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .pend_o  (pend),
    .mask_o  (mask),
    .force_o (frc),
    .en_o    (en),
    .lvl_o   (lvl)
  );

  assign act = (pend | frc) & en & ~mask;

  irq_prio_arb #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_arb (
    .act_i (act),
    .lvl_i (lvl),
    .hit_o (hit),
    .idx_o (win_idx),
    .lvl_o (win_lvl)
  );

  assign irq_level_o  = hit ? win_lvl : '0;
  assign irq_vector_o = hit ? VEC_W'(VEC_BASE) + VEC_W'(win_idx) : VEC_W'(VEC_IDLE);

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i >= AW'(LVL_BASE) && bus_addr_i < AW'(LVL_BASE + NUM_SRC)) begin
      bus_rdata_o = DW'(lvl[bus_addr_i[SEL_W-1:0]]);
    end else begin
      case (bus_addr_i)
        OFS_PEND_HI:  bus_rdata_o = DW'(pend[NUM_SRC-1:HALF]);
        OFS_PEND_LO:  bus_rdata_o = DW'(pend[HALF-1:0]);
        OFS_MASK_HI:  bus_rdata_o = DW'(mask[NUM_SRC-1:HALF]);
        OFS_MASK_LO:  bus_rdata_o = DW'(mask[HALF-1:0]);
        OFS_FORCE_HI: bus_rdata_o = DW'(frc[NUM_SRC-1:HALF]);
        OFS_FORCE_LO: bus_rdata_o = DW'(frc[HALF-1:0]);
        OFS_ACK:      bus_rdata_o = DW'(irq_vector_o);
        default:      bus_rdata_o = '0;
      endcase
    end
  end

  // independent check: does any active source beat the reported winner
  function automatic logic beaten(input logic [NUM_SRC-1:0] a,
                                  input logic [NUM_SRC-1:0][LVL_W-1:0] l,
                                  input logic [SEL_W-1:0] w);
    logic b;
    b = 1'b0;
    for (int j = 0; j < NUM_SRC; j++) begin
      if (a[j] && j > int'(w) && l[j] >= l[w]) b = 1'b1;
      if (a[j] && j < int'(w) && l[j] >  l[w]) b = 1'b1;
    end
    return b;
  endfunction

  // R6
  win_best_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |-> act[win_idx] && !beaten(act, lvl, win_idx));
  // R7
  idle_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act == '0 |-> irq_vector_o == VEC_W'(VEC_IDLE) && irq_level_o == '0);
  // R7
  vec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act != '0 |-> irq_vector_o >= VEC_W'(VEC_BASE));
  // R12
  ack_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_addr_i == OFS_ACK |-> bus_rdata_o == DW'(irq_vector_o));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 33;
  // entry: req[77:74] op[73:72] addr[71:64] data[63:32] exp[31:0]
  // op 0 = write, 1 = read compare, 2 = output compare {level, vector}
  localparam logic [77:0] TBL [NV] = '{
    {4'd1,  2'd1, 8'h08, 32'h0,        32'hFFFF_FFFF}, // R1 mask high
    {4'd1,  2'd1, 8'h0C, 32'h0,        32'hFFFF_FFFF}, // R1 mask low
    {4'd1,  2'd2, 8'h00, 32'h0,        32'h0000_0018}, // R1 idle outputs
    {4'd8,  2'd0, 8'h0C, 32'h0,        32'h0},         // R8 unmask low half
    {4'd8,  2'd1, 8'h0C, 32'h0,        32'h0},         // R8
    {4'd9,  2'd0, 8'h14, 32'h20,       32'h0},         // R9 force src5
    {4'd9,  2'd1, 8'h14, 32'h0,        32'h20},        // R9
    {4'd5,  2'd2, 8'h00, 32'h0,        32'h0000_0018}, // R5 not enabled
    {4'd4,  2'd0, 8'h45, 32'h3,        32'h0},         // R4 level src5=3
    {4'd7,  2'd2, 8'h00, 32'h0,        32'h0000_0345}, // R7 3/69
    {4'd4,  2'd1, 8'h45, 32'h0,        32'h3},         // R4
    {4'd12, 2'd1, 8'hE0, 32'h0,        32'h45},        // R12 ack
    {4'd9,  2'd0, 8'h10, 32'h1,        32'h0},         // R9 force src32
    {4'd4,  2'd0, 8'h60, 32'h3,        32'h0},         // R4 level src32=3
    {4'd5,  2'd2, 8'h00, 32'h0,        32'h0000_0345}, // R5 src32 masked
    {4'd11, 2'd0, 8'h1D, 32'd32,       32'h0},         // R11 clear bit 32
    {4'd6,  2'd2, 8'h00, 32'h0,        32'h0000_0360}, // R6 tie to higher
    {4'd11, 2'd1, 8'h08, 32'h0,        32'hFFFF_FFFE}, // R11
    {4'd6,  2'd0, 8'h45, 32'h7,        32'h0},         // R6 src5=7
    {4'd6,  2'd2, 8'h00, 32'h0,        32'h0000_0745}, // R6 level wins
    {4'd4,  2'd0, 8'h45, 32'h0,        32'h0},         // R4 disable src5
    {4'd4,  2'd2, 8'h00, 32'h0,        32'h0000_0360}, // R4
    {4'd10, 2'd0, 8'h1C, 32'd32,       32'h0},         // R10 set bit 32
    {4'd10, 2'd2, 8'h00, 32'h0,        32'h0000_0018}, // R10
    {4'd11, 2'd0, 8'h1D, 32'h40,       32'h0},         // R11 clear all
    {4'd11, 2'd1, 8'h08, 32'h0,        32'h0},         // R11
    {4'd11, 2'd2, 8'h00, 32'h0,        32'h0000_0360}, // R11
    {4'd10, 2'd0, 8'h1C, 32'h40,       32'h0},         // R10 set all
    {4'd10, 2'd1, 8'h0C, 32'h0,        32'hFFFF_FFFF}, // R10
    {4'd10, 2'd2, 8'h00, 32'h0,        32'h0000_0018}, // R10
    {4'd12, 2'd1, 8'h30, 32'h0,        32'h0},         // R12 unmapped
    {4'd8,  2'd0, 8'h08, 32'h0,        32'h0},         // R8 unmask high
    {4'd8,  2'd2, 8'h00, 32'h0,        32'h0000_0360}  // R8
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] irq_i = '0;
  logic        bus_we_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [7:0]  irq_level_o, irq_vector_o;
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  prio_irq_ctrl dut_i (
    .clk_i, .rst_ni, .irq_i, .bus_we_i, .bus_addr_i, .bus_wdata_i,
    .bus_rdata_o, .irq_level_o, .irq_vector_o
  );

  task automatic cmp(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input int req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr_i = a;
    #1;
    cmp(req, bus_rdata_o, exp);
  endtask

  task automatic outs(input int req, input logic [15:0] exp);
    #1;
    cmp(req, {16'h0, irq_level_o, irq_vector_o}, {16'h0, exp});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    outs(1, 16'h0018); // R1 under reset
    rst_ni = 1'b1;
    for (int k = 0; k < NV; k++) begin
      logic [77:0] e;
      e = TBL[k];
      case (e[73:72])
        2'd0:    wr(e[71:64], e[63:32]);
        2'd1:    rd(int'(e[77:74]), e[71:64], e[31:0]);
        default: outs(int'(e[77:74]), e[15:0]);
      endcase
    end
    // R13 / R2: request line to output latency
    wr(8'h7F, 32'd9);
    outs(13, 16'h0360);
    irq_i[63] = 1'b1;
    outs(13, 16'h0360);          // R13 no change before the edge
    @(negedge clk_i);
    outs(2, 16'h097F);           // R2 src63 level 9 vector 127
    rd(2, 8'h00, 32'h8000_0000); // R2
    rd(2, 8'h04, 32'h0);         // R2
    wr(8'h00, 32'h0);            // R3
    rd(3, 8'h00, 32'h8000_0000);
    wr(8'h04, 32'hFFFF_FFFF);    // R3
    rd(3, 8'h04, 32'h0);
    irq_i[63] = 1'b0;
    @(negedge clk_i);
    outs(13, 16'h0360);          // R13 drop seen after one edge
    // R1 reset return
    rst_ni = 1'b0;
    outs(1, 16'h0018);
    rd(1, 8'h08, 32'hFFFF_FFFF);
    rd(1, 8'h10, 32'h0);
    rd(1, 8'h60, 32'h0);
    rd(1, 8'h00, 32'h0);
    finish_run();
  end
endmodule